// File: doc/BRIEF.md
# Local Interrupt Vector Controller Core

This block is the vector-tracking core of a per-processor interrupt controller. Interrupt messages arrive as single-cycle strobes. Each message carries a vector number, a destination field, a destination-mode flag, a delivery-mode code and a trigger flag. The block keeps three bit arrays with one bit per vector:

- pending requests,
- vectors in service,
- the trigger kind recorded for each pending vector.

It also keeps two tracking registers: the highest pending vector and the highest in-service vector.

From these registers, a task-priority class and the processor's interrupt-enable flag, the block drives a single interrupt request to the processor. When the processor acknowledges, the block hands over the winning vector and moves it from pending to in service. An end-of-interrupt strobe retires the vector currently at the top of the in-service set. Delivery modes that cannot be masked are not serviced here. A message of that kind only raises a sticky error flag.

Top module: `lic_vector_core`

## Requirements
- R1: A message is accepted only when it targets this controller. With `msg_logical_i`=0 the destination field must equal `local_id_i`. With `msg_logical_i`=1 the destination bit whose index is `local_id_i` must be 1. Any other message changes no state.
- R2: Delivery codes 0 and 1 are maskable and are queued. Codes 2 through 7 are unmaskable: a targeted message with such a code queues nothing and sets the sticky `unsup_err_o`, which only reset clears.
- R3: An accepted maskable message whose request bit is 0 sets that request bit. In the same cycle it sets the vector's trigger bit when `msg_level_i`=1 (level) or clears it when `msg_level_i`=0 (edge).
- R4: An accepted message whose vector already has its request bit set leaves both the request bit and the trigger bit of that vector unchanged.
- R5: `ack_vector_o` always holds the index of the highest set request bit, or 0 when no request bit is set. It is updated in the cycle after any change to the request bits.
- R6: `irq_o` is 1 only when all three conditions hold:
  - the highest pending vector exceeds the highest in-service vector;
  - `intr_en_i`=1;
  - bits [7:4] of the highest pending vector exceed the stored task-priority class.
- R7: An acknowledge while `irq_o`=1 moves the vector shown on `ack_vector_o` into service. On the next cycle its in-service bit is set, its request bit is clear, `hi_svc_o` equals that vector, and `ack_vector_o` shows the next highest pending vector.
- R8: An acknowledge while `irq_o`=0 changes no pending or in-service state and sets the sticky `proto_err_o`.
- R9: An end-of-interrupt strobe clears the in-service bit of the current highest in-service vector. `hi_svc_o` then becomes the next highest set in-service bit, or 0 when none is left.
- R10: `tpr_we_i` loads `tpr_class_i` as the task-priority class. Reset clears all three arrays, both tracking registers, the class and both error flags.
- R11: When events coincide in one cycle, they take effect in a fixed order:
  - end-of-interrupt takes effect before acknowledge;
  - acknowledge takes effect before an incoming message, so a message for the vector being acknowledged queues it again with its new trigger kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_valid_i | input | 1 | Message strobe, one cycle per message |
| msg_vector_i | input | 8 | Vector carried by the message |
| msg_dest_i | input | 8 | Destination field |
| msg_logical_i | input | 1 | Destination mode: 0 physical, 1 logical |
| msg_deliv_i | input | 3 | Delivery-mode code |
| msg_level_i | input | 1 | Trigger flag: 1 level, 0 edge |
| local_id_i | input | 3 | Identity of this controller |
| tpr_we_i | input | 1 | Task-priority class write strobe |
| tpr_class_i | input | 4 | Task-priority class (upper nibble of task priority) |
| intr_en_i | input | 1 | Processor interrupt-enable flag |
| ack_i | input | 1 | Interrupt acknowledge from the processor |
| eoi_i | input | 1 | End-of-interrupt strobe |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_vector_o | output | 8 | Highest pending vector, delivered on acknowledge |
| hi_svc_o | output | 8 | Highest in-service vector |
| irr_o | output | 256 | Pending request bits |
| isr_o | output | 256 | In-service bits |
| tmr_o | output | 256 | Trigger-kind bits (1 level) |
| unsup_err_o | output | 1 | Sticky unmaskable-delivery flag |
| proto_err_o | output | 1 | Sticky illegal-acknowledge flag |

## Verification
On every cycle the assertions check these invariants:
- the bit named by each tracking register is really set in its array;
- an empty request array forces the pending tracker to 0;
- a legal acknowledge lands its vector in service;
- an illegal acknowledge raises the protocol flag;
- both error flags stay set once raised;
- a message for an already pending vector leaves the trigger bit alone.

The three-way gating of the request output, the destination filtering and the same-cycle ordering of acknowledge, end-of-interrupt and message can only be shown by the bench's scenarios. The bench's cycle model covers these in directed sequences and in a random phase.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int unsigned DELIV_W = 3;

  typedef enum logic [DELIV_W-1:0] {
    DM_FIXED  = 3'd0,
    DM_LOWEST = 3'd1,
    DM_SMI    = 3'd2,
    DM_RSVD   = 3'd3,
    DM_NMI    = 3'd4,
    DM_INIT   = 3'd5,
    DM_START  = 3'd6,
    DM_EXTINT = 3'd7
  } deliv_e;

  function automatic logic lic_is_maskable(deliv_e mode);
    return (mode == DM_FIXED) || (mode == DM_LOWEST);
  endfunction
endpackage

// File: rtl/lic_dest_filter.sv
module lic_dest_filter #(
  parameter  int unsigned ID_W   = 3,
  localparam int unsigned DEST_W = 1 << ID_W
) (
  input  logic [DEST_W-1:0] dest_i,
  input  logic              logical_i,
  input  logic [ID_W-1:0]   local_id_i,
  output logic              hit_o
);
  logic phys_hit, log_hit;

  assign phys_hit = !logical_i && (dest_i == DEST_W'(local_id_i));
  assign log_hit  = logical_i && dest_i[local_id_i];
  assign hit_o    = phys_hit || log_hit;
endmodule

// File: rtl/lic_prio_enc.sv
module lic_prio_enc #(
  parameter  int unsigned N = 256,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  output logic [W-1:0] idx_o
);
  // Highest set bit; empty input yields 0.
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (vec_i[i]) idx_o = W'(i);
    end
  end
endmodule

// File: rtl/lic_vec_bank.sv
module lic_vec_bank #(
  parameter  int unsigned N = 256,
  localparam int unsigned W = $clog2(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_set_i,
  input  logic [W-1:0] req_set_vec_i,
  input  logic         req_level_i,
  input  logic         req_clr_i,
  input  logic [W-1:0] req_clr_vec_i,
  input  logic         svc_set_i,
  input  logic [W-1:0] svc_set_vec_i,
  input  logic         svc_clr_i,
  input  logic [W-1:0] svc_clr_vec_i,
  output logic [N-1:0] irr_o,
  output logic [N-1:0] isr_o,
  output logic [N-1:0] tmr_o
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    logic irr_q, isr_q, tmr_q;
    logic r_clr, r_set, s_clr, s_set;

    assign r_clr = req_clr_i && (req_clr_vec_i == W'(g));
    // Clear from acknowledge is applied before a new message is merged.
    assign r_set = req_set_i && (req_set_vec_i == W'(g)) && (!irr_q || r_clr);
    assign s_clr = svc_clr_i && (svc_clr_vec_i == W'(g));
    assign s_set = svc_set_i && (svc_set_vec_i == W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        irr_q <= 1'b0;
        isr_q <= 1'b0;
        tmr_q <= 1'b0;
      end else begin
        if (r_set)      irr_q <= 1'b1;
        else if (r_clr) irr_q <= 1'b0;
        if (r_set)      tmr_q <= req_level_i;
        if (s_set)      isr_q <= 1'b1;
        else if (s_clr) isr_q <= 1'b0;
      end
    end

    assign irr_o[g] = irr_q;
    assign isr_o[g] = isr_q;
    assign tmr_o[g] = tmr_q;
  end
endmodule

// File: rtl/lic_vector_core.sv
module lic_vector_core
  import lic_pkg::*;
#(
  parameter  int unsigned VEC_W   = 8,
  parameter  int unsigned ID_W    = 3,
  parameter  int unsigned PRIO_W  = 4,
  localparam int unsigned NUM_VEC = 1 << VEC_W,
  localparam int unsigned DEST_W  = 1 << ID_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               msg_valid_i,
  input  logic [VEC_W-1:0]   msg_vector_i,
  input  logic [DEST_W-1:0]  msg_dest_i,
  input  logic               msg_logical_i,
  input  logic [DELIV_W-1:0] msg_deliv_i,
  input  logic               msg_level_i,
  input  logic [ID_W-1:0]    local_id_i,
  input  logic               tpr_we_i,
  input  logic [PRIO_W-1:0]  tpr_class_i,
  input  logic               intr_en_i,
  input  logic               ack_i,
  input  logic               eoi_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   ack_vector_o,
  output logic [VEC_W-1:0]   hi_svc_o,
  output logic [NUM_VEC-1:0] irr_o,
  output logic [NUM_VEC-1:0] isr_o,
  output logic [NUM_VEC-1:0] tmr_o,
  output logic               unsup_err_o,
  output logic               proto_err_o
);
  logic               dest_hit, maskable, accept, unsup_hit, ack_ok, irq_w;
  logic [VEC_W-1:0]   hi_pend_q, hi_pend_d, hi_svc_q, hi_svc_d;
  logic [VEC_W-1:0]   pend_rem, svc_rem, pend_after_ack;
  logic [PRIO_W-1:0]  tpr_q;
  logic               unsup_q, perr_q;
  logic [NUM_VEC-1:0] irr_w, isr_w, tmr_w, irr_rem, isr_rem;

  lic_dest_filter #(.ID_W(ID_W)) u_filt (
    .dest_i     (msg_dest_i),
    .logical_i  (msg_logical_i),
    .local_id_i (local_id_i),
    .hit_o      (dest_hit)
  );

  assign maskable  = lic_is_maskable(deliv_e'(msg_deliv_i));
  assign accept    = msg_valid_i && dest_hit && maskable;
  assign unsup_hit = msg_valid_i && dest_hit && !maskable;

  assign irq_w = (hi_pend_q > hi_svc_q) && intr_en_i &&
                 (hi_pend_q[VEC_W-1 -: PRIO_W] > tpr_q);
  assign ack_ok = ack_i && irq_w;

  lic_vec_bank #(.N(NUM_VEC)) u_bank (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_set_i     (accept),
    .req_set_vec_i (msg_vector_i),
    .req_level_i   (msg_level_i),
    .req_clr_i     (ack_ok),
    .req_clr_vec_i (hi_pend_q),
    .svc_set_i     (ack_ok),
    .svc_set_vec_i (hi_pend_q),
    .svc_clr_i     (eoi_i),
    .svc_clr_vec_i (hi_svc_q),
    .irr_o         (irr_w),
    .isr_o         (isr_w),
    .tmr_o         (tmr_w)
  );

  // Remaining sets once the retiring bit is removed.
  assign irr_rem = irr_w & ~({{(NUM_VEC-1){1'b0}}, ack_ok} << hi_pend_q);
  assign isr_rem = isr_w & ~({{(NUM_VEC-1){1'b0}}, eoi_i} << hi_svc_q);

  lic_prio_enc #(.N(NUM_VEC)) u_enc_pend (.vec_i(irr_rem), .idx_o(pend_rem));
  lic_prio_enc #(.N(NUM_VEC)) u_enc_svc  (.vec_i(isr_rem), .idx_o(svc_rem));

  always_comb begin
    pend_after_ack = ack_ok ? pend_rem : hi_pend_q;
    hi_pend_d      = pend_after_ack;
    if (accept && (msg_vector_i > pend_after_ack)) hi_pend_d = msg_vector_i;
  end

  // The acknowledged vector outranks every remaining in-service vector.
  always_comb begin
    hi_svc_d = hi_svc_q;
    if (ack_ok)     hi_svc_d = hi_pend_q;
    else if (eoi_i) hi_svc_d = svc_rem;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_pend_q <= '0;
      hi_svc_q  <= '0;
      tpr_q     <= '0;
      unsup_q   <= 1'b0;
      perr_q    <= 1'b0;
    end else begin
      hi_pend_q <= hi_pend_d;
      hi_svc_q  <= hi_svc_d;
      if (tpr_we_i)         tpr_q   <= tpr_class_i;
      if (unsup_hit)        unsup_q <= 1'b1;
      if (ack_i && !irq_w)  perr_q  <= 1'b1;
    end
  end

  assign irq_o        = irq_w;
  assign ack_vector_o = hi_pend_q;
  assign hi_svc_o     = hi_svc_q;
  assign irr_o        = irr_w;
  assign isr_o        = isr_w;
  assign tmr_o        = tmr_w;
  assign unsup_err_o  = unsup_q;
  assign proto_err_o  = perr_q;
endmodule

// File: rtl/lic_vector_core_sva.sv
module lic_vector_core_sva #(
  parameter  int unsigned VEC_W   = 8,
  localparam int unsigned NUM_VEC = 1 << VEC_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               msg_valid_i,
  input logic [VEC_W-1:0]   msg_vector_i,
  input logic               ack_i,
  input logic               irq_o,
  input logic [VEC_W-1:0]   ack_vector_o,
  input logic [VEC_W-1:0]   hi_svc_o,
  input logic [NUM_VEC-1:0] irr_o,
  input logic [NUM_VEC-1:0] isr_o,
  input logic [NUM_VEC-1:0] tmr_o,
  input logic               unsup_err_o,
  input logic               proto_err_o
);
  AST_ACK_TO_SVC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && irq_o |=> isr_o[$past(ack_vector_o)]); // R7

  AST_ACK_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !irq_o |=> proto_err_o); // R8

  AST_PERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> proto_err_o); // R8

  AST_UNSUP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsup_err_o |=> unsup_err_o); // R2

  AST_PEND_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irr_o == '0 |-> ack_vector_o == '0); // R5

  AST_PEND_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_vector_o != '0 |-> irr_o[ack_vector_o]); // R5

  AST_SVC_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_svc_o != '0 |-> isr_o[hi_svc_o]); // R9

  AST_TMR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_i && irr_o[msg_vector_i] && !ack_i
      |=> tmr_o[$past(msg_vector_i)] == $past(tmr_o[msg_vector_i])); // R4
endmodule

bind lic_vector_core lic_vector_core_sva #(.VEC_W(VEC_W)) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .msg_valid_i  (msg_valid_i),
  .msg_vector_i (msg_vector_i),
  .ack_i        (ack_i),
  .irq_o        (irq_o),
  .ack_vector_o (ack_vector_o),
  .hi_svc_o     (hi_svc_o),
  .irr_o        (irr_o),
  .isr_o        (isr_o),
  .tmr_o        (tmr_o),
  .unsup_err_o  (unsup_err_o),
  .proto_err_o  (proto_err_o)
);

// File: tb/lic_vector_core_tb.sv
module lic_vector_core_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         msg_valid = 1'b0;
  logic [7:0]   msg_vector = '0;
  logic [7:0]   msg_dest = '0;
  logic         msg_logical = 1'b0;
  logic [2:0]   msg_deliv = '0;
  logic         msg_level = 1'b0;
  logic [2:0]   local_id = 3'd3;
  logic         tpr_we = 1'b0;
  logic [3:0]   tpr_class = '0;
  logic         intr_en = 1'b0;
  logic         ack = 1'b0;
  logic         eoi = 1'b0;
  logic         irq;
  logic [7:0]   ack_vector, hi_svc;
  logic [255:0] irr, isr, tmr;
  logic         unsup_err, proto_err;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #4 clk = ~clk;

  lic_vector_core u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .msg_valid_i(msg_valid), .msg_vector_i(msg_vector), .msg_dest_i(msg_dest),
    .msg_logical_i(msg_logical), .msg_deliv_i(msg_deliv), .msg_level_i(msg_level),
    .local_id_i(local_id), .tpr_we_i(tpr_we), .tpr_class_i(tpr_class),
    .intr_en_i(intr_en), .ack_i(ack), .eoi_i(eoi),
    .irq_o(irq), .ack_vector_o(ack_vector), .hi_svc_o(hi_svc),
    .irr_o(irr), .isr_o(isr), .tmr_o(tmr),
    .unsup_err_o(unsup_err), .proto_err_o(proto_err)
  );

  // Behavioural reference model
  bit [255:0] m_irr, m_isr, m_tmr;
  int         m_hp, m_hs;
  int         m_tpr;
  bit         m_unsup, m_perr;

  function automatic int top_of(bit [255:0] v);
    for (int i = 255; i >= 0; i--) if (v[i]) return i;
    return 0;
  endfunction

  function automatic bit m_irq();
    return (m_hp > m_hs) && intr_en && ((m_hp / 16) > m_tpr);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_irr = '0; m_isr = '0; m_tmr = '0;
      m_hp = 0; m_hs = 0; m_tpr = 0; m_unsup = 0; m_perr = 0;
    end else begin
      bit fire, hit;
      fire = m_irq();
      if (eoi) m_isr[top_of(m_isr)] = 1'b0;
      if (ack) begin
        if (fire) begin
          m_isr[m_hp] = 1'b1;
          m_irr[m_hp] = 1'b0;
        end else m_perr = 1'b1;
      end
      hit = msg_logical ? msg_dest[local_id] : (int'(msg_dest) == int'(local_id));
      if (msg_valid && hit) begin
        if (msg_deliv <= 3'd1) begin
          if (!m_irr[msg_vector]) begin
            m_irr[msg_vector] = 1'b1;
            m_tmr[msg_vector] = msg_level;
          end
        end else m_unsup = 1'b1;
      end
      if (tpr_we) m_tpr = int'(tpr_class);
      m_hp = top_of(m_irr);
      m_hs = top_of(m_isr);
    end
  end

  task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 irq", 256'(irq), 256'(m_irq()));
      chk("R5 pending vector", 256'(ack_vector), 256'(m_hp));
      chk("R9 in-service vector", 256'(hi_svc), 256'(m_hs));
      chk("R3 request bits", irr, m_irr);
      chk("R7 in-service bits", isr, m_isr);
      chk("R4 trigger bits", tmr, m_tmr);
      chk("R2 unsup flag", 256'(unsup_err), 256'(m_unsup));
      chk("R8 protocol flag", 256'(proto_err), 256'(m_perr));
    end
  end

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic send(int v, int dest, bit logical, int deliv, bit level);
    msg_valid = 1'b1; msg_vector = 8'(v); msg_dest = 8'(dest);
    msg_logical = logical; msg_deliv = 3'(deliv); msg_level = level;
    cyc();
    msg_valid = 1'b0;
  endtask

  task automatic set_tpr(int c);
    tpr_we = 1'b1; tpr_class = 4'(c);
    cyc();
    tpr_we = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1; cyc(); ack = 1'b0;
  endtask

  task automatic do_eoi();
    eoi = 1'b1; cyc(); eoi = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL R10 watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    cyc();
    // R10: reset state
    chk("R10 reset irr", irr, '0);
    chk("R10 reset isr", isr, '0);
    chk("R10 reset irq", 256'(irq), 256'(0));
    intr_en = 1'b1;
    set_tpr(2);

    send(8'h45, 3, 1'b0, 0, 1'b0);
    chk("R3 edge queued", 256'({irr[8'h45], tmr[8'h45]}), 256'(2'b10));
    chk("R6 irq raised", 256'(irq), 256'(1));
    send(8'h45, 3, 1'b0, 0, 1'b1);
    chk("R4 trigger kept", 256'(tmr[8'h45]), 256'(0));
    send(8'h60, 5, 1'b0, 0, 1'b1);
    chk("R1 physical miss", 256'(irr[8'h60]), 256'(0));
    send(8'h60, 8'h08, 1'b1, 0, 1'b1);
    chk("R1 logical hit", 256'({irr[8'h60], tmr[8'h60]}), 256'(2'b11));
    chk("R5 raised", 256'(ack_vector), 256'(8'h60));
    send(8'h70, 8'h04, 1'b1, 0, 1'b0);
    chk("R1 logical miss", 256'(irr[8'h70]), 256'(0));
    send(8'h80, 3, 1'b0, 4, 1'b0);
    chk("R2 unmaskable", 256'({unsup_err, irr[8'h80]}), 256'(2'b10));
    send(8'h30, 3, 1'b0, 1, 1'b0);
    chk("R2 lowest-priority queued", 256'(irr[8'h30]), 256'(1));

    chk("R7 vector offered", 256'(ack_vector), 256'(8'h60));
    do_ack();
    chk("R7 moved", 256'({isr[8'h60], irr[8'h60]}), 256'(2'b10));
    chk("R7 svc", 256'(hi_svc), 256'(8'h60));
    chk("R6 blocked by svc", 256'(irq), 256'(0));
    do_ack();
    chk("R8 illegal ack", 256'({proto_err, hi_svc}), 256'({1'b1, 8'h60}));
    do_eoi();
    chk("R9 retired", 256'({isr[8'h60], hi_svc}), 256'(0));
    intr_en = 1'b0;
    cyc();
    chk("R6 disabled", 256'(irq), 256'(0));
    intr_en = 1'b1;
    set_tpr(4);
    chk("R6 class equal", 256'(irq), 256'(0));
    set_tpr(3);
    chk("R10 class written", 256'(irq), 256'(1));

    do_ack();
    send(8'h90, 3, 1'b0, 0, 1'b0);
    do_ack();
    do_eoi();
    chk("R9 nested return", 256'(hi_svc), 256'(8'h45));

    send(8'hA0, 3, 1'b0, 0, 1'b0);
    eoi = 1'b1; ack = 1'b1; cyc(); eoi = 1'b0; ack = 1'b0;
    chk("R11 eoi then ack", 256'({isr[8'h45], hi_svc}), 256'({1'b0, 8'hA0}));
    do_eoi();
    set_tpr(2);
    chk("R11 pre", 256'(ack_vector), 256'(8'h30));
    msg_valid = 1'b1; msg_vector = 8'h30; msg_dest = 8'd3; msg_logical = 1'b0;
    msg_deliv = 3'd0; msg_level = 1'b1; ack = 1'b1;
    cyc();
    msg_valid = 1'b0; ack = 1'b0;
    chk("R11 ack then message",
        256'({isr[8'h30], irr[8'h30], tmr[8'h30]}), 256'(3'b111));

    rst_n = 1'b0;
    cyc();
    chk("R10 mid-run reset", 256'({unsup_err, proto_err, irr == '0}), 256'(3'b001));
    rst_n = 1'b1;
    cyc();

    for (int k = 0; k < 600; k++) begin
      msg_valid   = ($urandom % 2) == 0;
      msg_vector  = 8'($urandom);
      msg_logical = 1'($urandom);
      msg_dest    = (($urandom % 2) == 0) ?
                    (msg_logical ? 8'(1 << local_id) : 8'(local_id)) : 8'($urandom);
      msg_deliv   = (($urandom % 16) == 0) ? 3'($urandom) : 3'($urandom % 2);
      msg_level   = 1'($urandom);
      ack         = ($urandom % 3) == 0;
      eoi         = ($urandom % 6) == 0;
      tpr_we      = ($urandom % 20) == 0;
      tpr_class   = 4'($urandom % 8);
      intr_en     = ($urandom % 10) != 0;
      cyc();
    end
    msg_valid = 1'b0; ack = 1'b0; eoi = 1'b0; tpr_we = 1'b0;
    cyc();
    finish_run();
  end
endmodule